// File: doc/BRIEF.md
# High/Low Count Clock Divider

This block divides an input clock by an integer ratio. The ratio is not stored as a single terminal count. Two 6-bit counts set it instead: one gives the number of input cycles the output stays high, the other the number of cycles it stays low. A half-cycle adjust bit moves the falling edge of the output half an input cycle later, so an odd ratio can have equal high and low times. A pass-through bit sends the input clock straight to the output, which is how a ratio of 1 is obtained.

Software or a sequencer writes two 16-bit configuration words through a one-cycle load strobe. The words are held in shadow registers. They become active only at the end of the current output period, so the output never shows a shortened or stretched pulse. A status port reports the ratio of the active configuration.

Top module: `hl_clk_divider`

## Requirements
- R1: Word A (load select 0) holds the low count in bits 5:0 and the high count in bits 11:6. With the adjust bit clear, the output is high for exactly the high count and then low for exactly the low count, in input cycles.
- R2: A count field of 0 stands for 64 input cycles, both for the output timing and for the reported ratio.
- R3: Word B (load select 1) bit 7 is the half-cycle adjust bit. When it is set, the high time becomes high count + 0.5 cycles and the low time becomes low count - 0.5 cycles. For an odd ratio N, programmed with high = floor(N/2) and low = N - high, the high and low times are therefore equal.
- R4: Word B bit 6 is the pass-through bit. While it is active, the output follows the input clock (divide by 1), whatever the counts.
- R5: `ratio_o` equals the high span plus the low span of the active configuration, or 1 while pass-through is active. It never reflects a configuration that is only held in the shadow registers.
- R6: A loaded word takes effect only at the end of the current output period. Until then, the output timing and `ratio_o` keep their previous values.
- R7: While `rst` is high, the output is low and the configuration returns to high count 1, low count 1, adjust 0, pass-through 0, so the ratio is 2. On the first rising input edge after `rst` falls, the output goes high and a new period starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | One-cycle strobe that writes `ld_data` into a shadow word |
| ld_sel | input | 1 | Selects the word: 0 for counts (word A), 1 for control bits (word B) |
| ld_data | input | 16 | Configuration word value |
| clk_o | output | 1 | Divided clock output |
| ratio_o | output | 8 | Ratio of the active configuration |

## Verification
The assertions assume that `rst` is held for at least one full input period, so the falling-edge stage is also cleared. They also assume that the load strobe carries only known values and lasts one cycle. The bench drives every load between rising edges and holds reset for several cycles. Output timing is measured only after a configuration has had more than two maximum-length periods to take effect. The shadow test is the exception: it loads a word deliberately in the middle of a long period and observes the output and the status port before and after the period boundary.

// File: rtl/hldiv_pkg.sv
package hldiv_pkg;
  localparam int CNT_W   = 6;
  localparam int WORD_W  = 16;
  localparam int RATIO_W = CNT_W + 2;
  localparam int LO_LSB  = 0;
  localparam int HI_LSB  = CNT_W;
  localparam int PASS_BIT = 6;
  localparam int ADJ_BIT  = 7;

  typedef struct packed {
    logic [CNT_W-1:0] hi_cnt;
    logic [CNT_W-1:0] lo_cnt;
    logic             half_adj;
    logic             pass;
  } div_cfg_t;

  function automatic div_cfg_t decode_cfg(input logic [WORD_W-1:0] wa,
                                          input logic [WORD_W-1:0] wb);
    div_cfg_t c;
    c.hi_cnt   = wa[HI_LSB +: CNT_W];
    c.lo_cnt   = wa[LO_LSB +: CNT_W];
    c.half_adj = wb[ADJ_BIT];
    c.pass     = wb[PASS_BIT];
    return c;
  endfunction

  function automatic logic [RATIO_W-1:0] span_of(input logic [CNT_W-1:0] f);
    logic [RATIO_W-1:0] s;
    s = (f == '0) ? RATIO_W'(1 << CNT_W) : RATIO_W'(f);
    return s;
  endfunction

  function automatic logic [RATIO_W-1:0] ratio_of(input div_cfg_t c);
    logic [RATIO_W-1:0] r;
    r = c.pass ? RATIO_W'(1) : span_of(c.hi_cnt) + span_of(c.lo_cnt);
    return r;
  endfunction
endpackage

// File: rtl/hldiv_shadow.sv
module hldiv_shadow
  import hldiv_pkg::*;
#(
  parameter logic [WORD_W-1:0] RST_WA = 16'h0041,
  parameter logic [WORD_W-1:0] RST_WB = 16'h0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_en,
  input  logic              ld_sel,
  input  logic [WORD_W-1:0] ld_data,
  input  logic              boundary,
  output div_cfg_t          nxt_cfg,
  output div_cfg_t          act_cfg,
  output logic [RATIO_W-1:0] ratio
);
  logic [WORD_W-1:0] sh_wa, sh_wb;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_wa <= RST_WA;
      sh_wb <= RST_WB;
    end else if (ld_en) begin
      if (ld_sel) sh_wb <= ld_data;
      else        sh_wa <= ld_data;
    end
  end

  assign nxt_cfg = decode_cfg(sh_wa, sh_wb);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_cfg <= decode_cfg(RST_WA, RST_WB);
      ratio   <= ratio_of(decode_cfg(RST_WA, RST_WB));
    end else if (boundary) begin
      act_cfg <= nxt_cfg;
      ratio   <= ratio_of(nxt_cfg);
    end
  end

  assert_hold_between_bounds_R6: assert property (@(posedge clk) disable iff (rst)
    !boundary |=> ($stable(act_cfg) && $stable(ratio)));
endmodule

// File: rtl/hldiv_count.sv
module hldiv_count
  import hldiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] nxt_hi,
  input  logic [CNT_W-1:0] act_lo,
  output logic             boundary,
  output logic             out_hi
);
  logic             phase_hi;
  logic [CNT_W-1:0] rem;

  assign boundary = !phase_hi && (rem == '0);
  assign out_hi   = phase_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_hi <= 1'b0;
      rem      <= '0;
    end else if (rem == '0) begin
      phase_hi <= !phase_hi;
      rem      <= phase_hi ? act_lo - 1'b1 : nxt_hi - 1'b1;
    end else begin
      rem <= rem - 1'b1;
    end
  end

  assert_phase_countdown_R1: assert property (@(posedge clk) disable iff (rst)
    (rem != '0) |=> ($stable(phase_hi) && (rem == $past(rem) - 1'b1)));
  assert_period_restart_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(out_hi) |-> $past(boundary));
endmodule

// File: rtl/hldiv_halfedge.sv
module hldiv_halfedge (
  input  logic clk,
  input  logic rst,
  input  logic out_hi,
  input  logic half_adj,
  input  logic pass,
  output logic clk_o
);
  logic q_neg;

  always_ff @(negedge clk) begin
    if (rst) q_neg <= 1'b0;
    else     q_neg <= out_hi;
  end

  assign clk_o = pass ? clk : (out_hi | (half_adj & q_neg));

  assert_half_track_R3: assert property (@(posedge clk) disable iff (rst)
    q_neg == out_hi);
endmodule

// File: rtl/hl_clk_divider.sv
module hl_clk_divider
  import hldiv_pkg::*;
#(
  parameter logic [15:0] RST_WA = 16'h0041,
  parameter logic [15:0] RST_WB = 16'h0000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ld_en,
  input  logic        ld_sel,
  input  logic [15:0] ld_data,
  output logic        clk_o,
  output logic [7:0]  ratio_o
);
  div_cfg_t nxt_cfg, act_cfg;
  logic     boundary, out_hi;
  logic [RATIO_W-1:0] ratio;

  hldiv_shadow #(.RST_WA(RST_WA), .RST_WB(RST_WB)) u_shadow (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
    .boundary(boundary), .nxt_cfg(nxt_cfg), .act_cfg(act_cfg), .ratio(ratio)
  );

  hldiv_count u_count (
    .clk(clk), .rst(rst), .nxt_hi(nxt_cfg.hi_cnt), .act_lo(act_cfg.lo_cnt),
    .boundary(boundary), .out_hi(out_hi)
  );

  hldiv_halfedge u_edge (
    .clk(clk), .rst(rst), .out_hi(out_hi), .half_adj(act_cfg.half_adj),
    .pass(act_cfg.pass), .clk_o(clk_o)
  );

  assign ratio_o = ratio;

  assert_pass_ratio_R4: assert property (@(posedge clk) disable iff (rst)
    act_cfg.pass |-> (ratio_o == 8'd1));
  assert_count_ratio_R5: assert property (@(posedge clk) disable iff (rst)
    !act_cfg.pass |-> (ratio_o >= 8'd2));
endmodule

// File: tb/sim_hl_clk_divider.sv
module sim_hl_clk_divider;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ld_en = 1'b0;
  logic ld_sel = 1'b0;
  logic [15:0] ld_data = '0;
  logic clk_o;
  logic [7:0] ratio_o;
  int checks = 0;
  int fails = 0;

  typedef struct {
    int    hi;
    int    lo;
    string tag;
  } per_t;
  per_t exp_q[$];

  always #10 clk = ~clk;

  hl_clk_divider u0 (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
    .clk_o(clk_o), .ratio_o(ratio_o)
  );

  function automatic logic [15:0] mk(input int h, input int l);
    return 16'(((h & 63) << 6) | (l & 63));
  endfunction

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic load(input logic sel, input logic [15:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_sel = sel; ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic setup(input logic [15:0] wa, input logic [15:0] wb);
    load(1'b0, wa);
    load(1'b1, wb);
    repeat (300) @(negedge clk);
  endtask

  task automatic expect_per(input int hi, input int lo, input string tag, input int n);
    for (int i = 0; i < n; i++) begin
      per_t p;
      p.hi = hi; p.lo = lo; p.tag = tag;
      exp_q.push_back(p);
    end
    wait (exp_q.size() == 0);
  endtask

  // monitor: samples the output once in every input half cycle
  task automatic half(output logic s);
    @(clk);
    #5;
    s = clk_o;
  endtask

  initial begin
    logic s;
    forever begin
      int hi, lo;
      per_t p;
      wait (exp_q.size() != 0);
      half(s);
      while (s != 1'b0) half(s);
      while (s != 1'b1) half(s);
      hi = 0;
      while (s == 1'b1) begin hi++; half(s); end
      lo = 0;
      while (s == 1'b0) begin lo++; half(s); end
      p = exp_q.pop_front();
      chk(hi, p.hi, {p.tag, " high half-cycles"});
      chk(lo, p.lo, {p.tag, " low half-cycles"});
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(int'(clk_o), 0, "R7 output low in reset");
    chk(int'(ratio_o), 2, "R7 reset ratio");
    rst = 1'b0;
    @(posedge clk); #5;
    chk(int'(clk_o), 1, "R7 high after first edge");
    expect_per(2, 2, "R7 reset config", 2);

    setup(mk(3, 5), 16'h0000);
    chk(int'(ratio_o), 8, "R5 ratio 3+5");
    expect_per(6, 10, "R1 high3 low5", 2);

    setup(mk(3, 4), 16'h0080);
    chk(int'(ratio_o), 7, "R5 ratio odd 7");
    expect_per(7, 7, "R3 odd 7 balanced", 2);

    setup(mk(1, 2), 16'h0080);
    expect_per(3, 3, "R3 odd 3 balanced", 2);

    setup(mk(0, 0), 16'h0000);
    chk(int'(ratio_o), 128, "R2 zero fields ratio");
    expect_per(128, 128, "R2 zero fields", 1);

    setup(mk(0, 2), 16'h0000);
    chk(int'(ratio_o), 66, "R2 zero high ratio");
    expect_per(128, 4, "R2 zero high", 1);

    setup(mk(5, 7), 16'h0040);
    chk(int'(ratio_o), 1, "R4 R5 pass ratio");
    expect_per(1, 1, "R4 pass-through", 3);

    setup(mk(40, 40), 16'h0000);
    chk(int'(ratio_o), 80, "R5 ratio 80");
    @(posedge clk_o);
    repeat (3) @(negedge clk);
    load(1'b0, mk(3, 3));
    repeat (5) @(negedge clk);
    chk(int'(ratio_o), 80, "R6 ratio held before boundary");
    chk(int'(clk_o), 1, "R6 high phase not cut");
    repeat (100) @(negedge clk);
    chk(int'(ratio_o), 6, "R6 ratio after boundary");
    expect_per(6, 6, "R6 new config", 2);

    finish_up();
  end
endmodule